// File: doc/BRIEF.md
# Iterative Divide and Multiply Unit

This block is a sequential 32-bit arithmetic engine for a processor execution stage. It computes the unsigned and signed quotient and remainder of two operands, the low word of their product, and the high word of their unsigned 64-bit product. A 4-bit operation code picks the function. The caller raises `start` for one cycle while the unit is idle. `busy` then stays high until the result is ready, and `done` pulses for exactly one cycle with the result on `result`.

The unit has one shared shift datapath. For division it runs a restoring algorithm that produces one quotient bit per cycle. For multiplication it runs a shift-and-add loop that handles one multiplier bit per cycle. Signed division works on operand magnitudes, and the signs are applied to the quotient and remainder in a final cycle.

Each outcome is defined, including the corner cases. Signed division truncates toward zero, and the remainder takes the sign of the dividend. Division by zero does not trap. An unsupported operation code finishes at once and flags `illegal`.

Top module: `divmul_unit`

## Requirements
- R1: After reset, `busy`, `done` and `illegal` are 0 and `result` is 0.
- R2: The operation codes are: 0 = unsigned quotient, 1 = unsigned remainder, 2 = signed quotient, 3 = signed remainder, 8 = low W bits of the product, 9 = high W bits of the unsigned 2W-bit product.
- R3: Signed quotients truncate toward zero, and a signed remainder carries the sign of the dividend.
- R4: Signed quotient of the most negative value (only the top bit set) by all-ones returns the most negative value. The signed remainder of the same operands returns 0.
- R5: A divisor of 0 gives an all-ones quotient (codes 0 and 2) and returns the dividend unchanged as the remainder (codes 1 and 3).
- R6: A legal start accepted in cycle 0 (`start` high while `busy` is low) raises `busy` after that edge. `done` is then high for one cycle, W+1 edges after the accepting edge, and `busy` falls at the same edge.
- R7: `done` never stays high for two consecutive cycles, and `done` and `busy` are never high together.
- R8: A `start` raised while `busy` is high is ignored. The running operation finishes with its own result, and no extra `done` follows.
- R9: Any code other than 0, 1, 2, 3, 8 or 9 is accepted without `busy`. `done` and `illegal` go high together on the next edge, with `result` equal to 0. `illegal` is high only together with `done`.
- R10: `result` holds its value between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when the unit is idle |
| func | input | 4 | Operation code, sampled with start |
| opa | input | W | Dividend or multiplicand |
| opb | input | W | Divisor or multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Unsupported code, valid with done |
| result | output | W | Result of the last completed operation |

## Verification
A wrong internal state shows at the ports within a single operation. A bad quotient bit, a missed carry in the multiply loop, or a wrong sign-fix flag changes `result` at the next `done`. A counter that stops early or late moves `done` away from the W+1 edge point, and the latency check catches that on the first legal operation. The operand sweep crosses small magnitudes of both signs with the extreme values, so a sign-correction error or a mishandled zero divisor shows up in the first pass over those pairs.

// File: rtl/divmul_unit.sv
module divmul_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [3:0]   func,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         done,
  output logic         illegal,
  output logic [W-1:0] result
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [3:0]   fn;
  logic [W-1:0] hi_r, lo_r, dvs_r, dnd_r;
  logic         neg_q, neg_r;

  wire legal  = (func == 4'd0) || (func == 4'd1) || (func == 4'd2) ||
                (func == 4'd3) || (func == 4'd8) || (func == 4'd9);
  wire sgn    = (func == 4'd2) || (func == 4'd3);
  wire a_neg  = sgn & opa[W-1];
  wire b_neg  = sgn & opb[W-1];
  wire accept = start && (st == S_IDLE);

  wire [W:0] trial = {hi_r, lo_r[W-1]} - {1'b0, dvs_r};
  wire [W:0] msum  = {1'b0, hi_r} + (lo_r[0] ? {1'b0, dvs_r} : '0);
  wire       dz    = (dvs_r == '0);

  logic [W-1:0] fin;
  always_comb begin
    case (fn)
      4'd0:    fin = dz ? '1 : lo_r;
      4'd1:    fin = dz ? dnd_r : hi_r;
      4'd2:    fin = dz ? '1 : (neg_q ? -lo_r : lo_r);
      4'd3:    fin = dz ? dnd_r : (neg_r ? -hi_r : hi_r);
      4'd9:    fin = hi_r;
      default: fin = lo_r;
    endcase
  end

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; fn <= '0;
      hi_r <= '0; lo_r <= '0; dvs_r <= '0; dnd_r <= '0;
      neg_q <= 1'b0; neg_r <= 1'b0;
      done <= 1'b0; illegal <= 1'b0; result <= '0;
    end else begin
      done <= 1'b0;
      illegal <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          if (!legal) begin
            done <= 1'b1;
            illegal <= 1'b1;
            result <= '0;
          end else begin
            st <= S_RUN;
            cnt <= '0;
            fn <= func;
            hi_r <= '0;
            dnd_r <= opa;
            neg_q <= a_neg ^ b_neg;
            neg_r <= a_neg;
            lo_r <= a_neg ? -opa : opa;
            dvs_r <= b_neg ? -opb : opb;
          end
        end
        S_RUN: begin
          if (fn[3]) begin
            hi_r <= msum[W:1];
            lo_r <= {msum[0], lo_r[W-1:1]};
          end else if (!trial[W]) begin
            hi_r <= trial[W-1:0];
            lo_r <= {lo_r[W-2:0], 1'b1};
          end else begin
            hi_r <= {hi_r[W-2:0], lo_r[W-1]};
            lo_r <= {lo_r[W-2:0], 1'b0};
          end
          cnt <= cnt + 1'b1;
          if (cnt == LAST) st <= S_FIN;
        end
        default: begin
          result <= fin;
          done <= 1'b1;
          st <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/divmul_unit_chk.sv
module divmul_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [3:0]   func,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         busy,
  input logic         done,
  input logic         illegal,
  input logic [W-1:0] result
);
  localparam logic [W-1:0] MOSTNEG = {1'b1, {(W-1){1'b0}}};

  logic [15:0]  lat;
  logic [3:0]   c_fn;
  logic [W-1:0] c_a, c_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat <= '0; c_fn <= '0; c_a <= '0; c_b <= '0;
    end else if (start && !busy) begin
      lat <= '0; c_fn <= func; c_a <= opa; c_b <= opb;
    end else if (busy) begin
      lat <= lat + 1'b1;
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  // R9
  illegal_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);

  // R9
  illegal_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (result == '0));

  // R6
  legal_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (func inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd8, 4'd9})) |=> busy);

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal) |-> (lat == 16'(W + 1)));

  // R4
  minneg_quot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && c_fn == 4'd2 && c_a == MOSTNEG && c_b == '1) |-> (result == MOSTNEG));

  // R4
  minneg_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && c_fn == 4'd3 && c_a == MOSTNEG && c_b == '1) |-> (result == '0));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || $stable(result)));
endmodule

bind divmul_unit divmul_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .func(func), .opa(opa), .opb(opb),
  .busy(busy), .done(done), .illegal(illegal), .result(result)
);

// File: tb/sim_divmul_unit.sv
`timescale 1ns/1ps
module sim_divmul_unit;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [3:0]   func = '0;
  logic [W-1:0] opa = '0, opb = '0;
  logic         busy, done, illegal;
  logic [W-1:0] result;

  int checks = 0;
  int fails = 0;
  bit timed_out = 1'b0;

  always #10 clk = ~clk;

  divmul_unit #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .func(func), .opa(opa), .opb(opb),
    .busy(busy), .done(done), .illegal(illegal), .result(result)
  );

  logic [W-1:0] vals [16];

  function automatic logic [W-1:0] model(input logic [3:0] f, input logic [W-1:0] a,
                                         input logic [W-1:0] b);
    longint sa, sb, t;
    logic [2*W-1:0] p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    case (f)
      4'd0: return (b == 0) ? '1 : a / b;
      4'd1: return (b == 0) ? a : a % b;
      4'd2: begin if (b == 0) return '1; t = sa / sb; return t[W-1:0]; end
      4'd3: begin if (b == 0) return a; t = sa % sb; return t[W-1:0]; end
      4'd8: return p[W-1:0];
      default: return p[2*W-1:W];
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic launch(input logic [3:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
    func = f; opa = a; opb = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int k);
    k = 0;
    while (!done && k < 200) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic run_op(input logic [3:0] f, input logic [W-1:0] a, input logic [W-1:0] b,
                        input string req);
    int k;
    logic [W-1:0] e;
    launch(f, a, b);
    wait_done(k);
    e = model(f, a, b);
    check(result == e && !illegal, req, result, e);
  endtask

  initial begin
    #4000000;
    timed_out = 1'b1;
  end

  initial begin
    int k;
    logic [W-1:0] held;
    logic [3:0] fl [6];
    vals = '{32'h0, 32'h1, 32'h2, 32'h3, 32'h5, 32'h7, 32'hFFFF_FFFF, 32'hFFFF_FFFE,
             32'hFFFF_FFFD, 32'hFFFF_FFF9, 32'h8000_0000, 32'h7FFF_FFFF, 32'h1234_5678,
             32'hDEAD_BEEF, 32'hFFFF_0000, 32'd100};
    fl = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd8, 4'd9};

    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !illegal, "R1", {29'b0, busy, done, illegal}, '0);
    check(result == '0, "R1", result, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 latency and handshake
    launch(4'd0, 32'd100, 32'd7);
    check(busy, "R6", {31'b0, busy}, 1);
    wait_done(k);
    check(k == W + 1, "R6", k, W + 1);
    check(!busy, "R6", {31'b0, busy}, 0);
    @(negedge clk);
    // R7 done is a single pulse
    check(!done, "R7", {31'b0, done}, 0);
    // R10 result held
    check(result == 32'd14, "R10", result, 32'd14);

    // R4 overflow corner
    run_op(4'd2, 32'h8000_0000, 32'hFFFF_FFFF, "R4");
    check(result == 32'h8000_0000, "R4", result, 32'h8000_0000);
    run_op(4'd3, 32'h8000_0000, 32'hFFFF_FFFF, "R4");
    check(result == 32'h0, "R4", result, 32'h0);

    // R5 divide by zero
    run_op(4'd2, 32'hFFFF_FFF9, 32'h0, "R5");
    check(result == 32'hFFFF_FFFF, "R5", result, 32'hFFFF_FFFF);
    run_op(4'd3, 32'hFFFF_FFF9, 32'h0, "R5");
    check(result == 32'hFFFF_FFF9, "R5", result, 32'hFFFF_FFF9);

    // R3 truncation toward zero, remainder sign follows dividend
    run_op(4'd2, 32'hFFFF_FFF9, 32'd2, "R3");
    check(result == 32'hFFFF_FFFD, "R3", result, 32'hFFFF_FFFD);
    run_op(4'd3, 32'hFFFF_FFF9, 32'd2, "R3");
    check(result == 32'hFFFF_FFFF, "R3", result, 32'hFFFF_FFFF);
    run_op(4'd3, 32'd7, 32'hFFFF_FFFE, "R3");
    check(result == 32'd1, "R3", result, 32'd1);

    // R8 start while busy is ignored
    launch(4'd8, 32'd6, 32'd7);
    repeat (5) @(negedge clk);
    launch(4'd0, 32'd9, 32'd3);
    wait_done(k);
    check(result == 32'd42, "R8", result, 32'd42);
    held = result;
    k = 0;
    repeat (W + 4) begin
      @(negedge clk);
      if (done) k++;
    end
    check(k == 0, "R8", k, 0);
    check(result == held, "R10", result, held);

    // R9 unsupported codes
    for (int f = 0; f < 16; f++) begin
      if (f inside {0, 1, 2, 3, 8, 9}) continue;
      launch(4'(f), 32'h55, 32'h3);
      check(done && illegal && !busy, "R9", {29'b0, done, illegal, busy}, 32'b110);
      check(result == '0, "R9", result, '0);
      @(negedge clk);
      check(!illegal && !done, "R9", {30'b0, done, illegal}, 0);
    end

    // R2 sweep of all legal codes over the operand set
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        for (int f = 0; f < 6; f++) begin
          if (timed_out) break;
          run_op(fl[f], vals[i], vals[j], "R2");
        end

    if (timed_out) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule